// File: doc/BRIEF.md
# Phase-Wrapping Integral Path

This block is the integral branch of a digital PI controller that drives an actuator whose effect repeats every fixed span of output voltage, such as an electro-optic phase shifter in an optical phase lock. Each clock it registers the product of a signed error sample and a signed integral gain, then adds that product to a wide integral register. When the sum would cross the upper or lower limit, the block does not clamp it. It moves the sum by a programmable wrap amount, one actuator period, so the loop relocks at an equivalent operating point one period away.

The internal register spans four times the range the output stage can drive. The limits and the wrap amount are given in output-scale units, so the integrator stays within what the converter can produce. A host preload sets the integral directly. Two single-cycle pulses report upward and downward wraps, so surrounding logic can count whole periods. A sticky flag records any case where a wrap could not bring the value back inside the limits, and the value was clamped.

Top module: `pwi_phase_integrator`

## Requirements
- R1: The product `err_i * ki_i` is registered on one clock edge and added to the integral register on the next edge, so an error sample affects `int_o` two edges after it is applied.
- R2: If the sum exceeds `lim_hi_i` (scaled by 2^FRAC_W) and the sum minus the wrap amount (scaled by 2^FRAC_W) lies within the limits, the register takes that shifted value and `wrap_up_o` is high for the following cycle.
- R3: If the sum falls below `lim_lo_i` (scaled) and the sum plus the wrap amount (scaled) lies within the limits, the register takes that shifted value and `wrap_dn_o` is high for the following cycle.
- R4: If the shifted value is still outside the limits, the register is clamped to the crossed limit, no wrap pulse is raised, and `wrap_err_o` is set and stays set until reset.
- R5: A preload write loads the register with `pre_val_i` sign-extended by two bits at the top and padded with FRAC_W zero bits at the bottom, so `int_o` equals `pre_val_i` on the next cycle.
- R6: A preload write takes priority over the accumulate and wrap update in the same cycle, and raises neither wrap pulse.
- R7: The sum carries one guard bit above the register width. A top-two-bit pattern of 01 is treated as crossing the upper limit, and 10 as crossing the lower limit.
- R8: After any accumulate update, with `lim_lo_i <= lim_hi_i`, `int_o` lies within [`lim_lo_i`, `lim_hi_i`].
- R9: `int_o` is the register divided by 2^FRAC_W, rounded toward zero.
- R10: A synchronous active-high `rst` clears the product register, the integral register, both wrap pulses and the error flag.
- R11: `wrap_up_o` and `wrap_dn_o` are never high together, and each marks exactly one wrap update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_i | input | ERR_W | Signed error sample |
| ki_i | input | KI_W | Signed integral gain |
| lim_hi_i | input | OUT_W | Signed upper limit, output scale |
| lim_lo_i | input | OUT_W | Signed lower limit, output scale |
| wrap_amt_i | input | OUT_W | Unsigned wrap amount, one actuator period in output LSBs |
| pre_we_i | input | 1 | Preload write strobe |
| pre_val_i | input | OUT_W | Signed preload value, output scale |
| int_o | output | OUT_W | Integral term, rounded toward zero |
| wrap_up_o | output | 1 | Pulse: an upper crossing was wrapped down |
| wrap_dn_o | output | 1 | Pulse: a lower crossing was wrapped up |
| wrap_err_o | output | 1 | Sticky: a wrap failed and the value was clamped |

## Verification
The bench builds the block with ERR_W=14 and KI_W=13. This is one gain bit wider than the default, so the largest product fills the full guard-extended sum. That makes the 01 and 10 guard patterns reachable, which never occurs with the default gain width. OUT_W=16 and FRAC_W=8 are kept. With these values, narrow limits combined with a wrap amount larger than the limit span reach the clamp path. Small negative sums exercise rounding toward zero.

// File: rtl/pwi_pkg.sv
package pwi_pkg;

    // Weight of the internal range above the output range: 2 bits = 4x.
    localparam int HEAD_W = 2;

    typedef enum logic [2:0] {
        STEP_PASS,
        STEP_UP,
        STEP_DN,
        STEP_CLAMP_HI,
        STEP_CLAMP_LO
    } step_kind_e;

    typedef enum logic [1:0] {
        GUARD_OK,
        GUARD_POS,
        GUARD_NEG
    } guard_e;

    // Classify the sign bit and the guard bit of the extended sum.
    function automatic guard_e classify_guard(input logic [1:0] top);
        case (top)
            2'b01:   return GUARD_POS;
            2'b10:   return GUARD_NEG;
            default: return GUARD_OK;
        endcase
    endfunction

    function automatic logic is_clamp(input step_kind_e k);
        return (k == STEP_CLAMP_HI) || (k == STEP_CLAMP_LO);
    endfunction

endpackage

// File: rtl/pwi_gain_mult.sv
module pwi_gain_mult #(
    parameter int ERR_W  = 14,
    parameter int KI_W   = 12,
    parameter int PROD_W = ERR_W + KI_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic signed [KI_W-1:0]   ki_i,
    output logic signed [PROD_W-1:0] prod_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_o <= '0;
        end else begin
            prod_o <= err_i * ki_i;
        end
    end

endmodule

// File: rtl/pwi_wrap_step.sv
module pwi_wrap_step
    import pwi_pkg::*;
#(
    parameter int ACC_W  = 26,
    parameter int PROD_W = 26,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic signed [ACC_W-1:0]  acc_i,
    input  logic signed [PROD_W-1:0] prod_i,
    input  logic signed [OUT_W-1:0]  hi_i,
    input  logic signed [OUT_W-1:0]  lo_i,
    input  logic        [OUT_W-1:0]  wrap_i,
    output logic signed [ACC_W-1:0]  nxt_o,
    output step_kind_e               kind_o
);

    localparam int SUM_W  = ACC_W + 1;
    localparam int WIDE_W = ACC_W + 2;
    localparam int PAD_W  = WIDE_W - OUT_W - FRAC_W;

    logic signed [SUM_W-1:0]  acc_x;
    logic signed [SUM_W-1:0]  prod_x;
    logic signed [SUM_W-1:0]  sum;
    logic signed [WIDE_W-1:0] sum_w, hi_w, lo_w, wrap_w, up_w, dn_w, nxt_w;
    guard_e                   guard;
    logic                     above, below, up_fits, dn_fits;
    logic                     unused_top;

    assign acc_x = {acc_i[ACC_W-1], acc_i};

    // Sign-extend the product only when it is narrower than the sum.
    generate
        if (PROD_W == SUM_W) begin : g_prod_full
            assign prod_x = prod_i;
        end else begin : g_prod_ext
            assign prod_x = {{(SUM_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
        end
    endgenerate

    assign sum   = acc_x + prod_x;
    assign guard = classify_guard(sum[SUM_W-1:SUM_W-2]);

    assign sum_w  = {sum[SUM_W-1], sum};
    assign hi_w   = {{PAD_W{hi_i[OUT_W-1]}}, hi_i, {FRAC_W{1'b0}}};
    assign lo_w   = {{PAD_W{lo_i[OUT_W-1]}}, lo_i, {FRAC_W{1'b0}}};
    assign wrap_w = {{PAD_W{1'b0}}, wrap_i, {FRAC_W{1'b0}}};

    assign up_w = sum_w - wrap_w;
    assign dn_w = sum_w + wrap_w;

    assign above = (guard == GUARD_POS) || ((guard == GUARD_OK) && (sum_w > hi_w));
    assign below = (guard == GUARD_NEG) || ((guard == GUARD_OK) && (sum_w < lo_w));

    assign up_fits = (up_w <= hi_w) && (up_w >= lo_w);
    assign dn_fits = (dn_w <= hi_w) && (dn_w >= lo_w);

    always_comb begin
        kind_o = STEP_PASS;
        nxt_w  = sum_w;
        if (above) begin
            if (up_fits) begin
                kind_o = STEP_UP;
                nxt_w  = up_w;
            end else begin
                kind_o = STEP_CLAMP_HI;
                nxt_w  = hi_w;
            end
        end else if (below) begin
            if (dn_fits) begin
                kind_o = STEP_DN;
                nxt_w  = dn_w;
            end else begin
                kind_o = STEP_CLAMP_LO;
                nxt_w  = lo_w;
            end
        end
    end

    // Every selected value lies within the limits, so the top bits are sign copies.
    assign nxt_o      = nxt_w[ACC_W-1:0];
    assign unused_top = ^nxt_w[WIDE_W-1:ACC_W];

endmodule

// File: rtl/pwi_out_round.sv
module pwi_out_round #(
    parameter int ACC_W  = 26,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic signed [ACC_W-1:0] acc_i,
    output logic signed [OUT_W-1:0] out_o
);

    logic signed [ACC_W-1:0] shifted;
    logic signed [ACC_W-1:0] rounded;
    logic                    frac_nz;
    logic                    bump;
    logic                    unused_hi;

    assign shifted = acc_i >>> FRAC_W;
    assign frac_nz = |acc_i[FRAC_W-1:0];
    // A negative value with discarded fraction moves up by one toward zero.
    assign bump    = acc_i[ACC_W-1] & frac_nz;
    assign rounded = shifted + {{(ACC_W-1){1'b0}}, bump};

    assign out_o     = rounded[OUT_W-1:0];
    assign unused_hi = ^rounded[ACC_W-1:OUT_W];

endmodule

// File: rtl/pwi_phase_integrator.sv
module pwi_phase_integrator
    import pwi_pkg::*;
#(
    parameter int ERR_W  = 14,
    parameter int KI_W   = 12,
    parameter int OUT_W  = 16,
    parameter int FRAC_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [ERR_W-1:0] err_i,
    input  logic signed [KI_W-1:0]  ki_i,
    input  logic signed [OUT_W-1:0] lim_hi_i,
    input  logic signed [OUT_W-1:0] lim_lo_i,
    input  logic        [OUT_W-1:0] wrap_amt_i,
    input  logic                    pre_we_i,
    input  logic signed [OUT_W-1:0] pre_val_i,
    output logic signed [OUT_W-1:0] int_o,
    output logic                    wrap_up_o,
    output logic                    wrap_dn_o,
    output logic                    wrap_err_o
);

    // PROD_W must not exceed ACC_W + 1; FRAC_W must be at least 1.
    localparam int PROD_W = ERR_W + KI_W;
    localparam int ACC_W  = OUT_W + FRAC_W + HEAD_W;

    logic signed [PROD_W-1:0] prod_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  acc_nxt;
    logic signed [ACC_W-1:0]  pre_ext;
    step_kind_e               kind;

    pwi_gain_mult #(
        .ERR_W  (ERR_W),
        .KI_W   (KI_W),
        .PROD_W (PROD_W)
    ) u_mult (
        .clk    (clk),
        .rst    (rst),
        .err_i  (err_i),
        .ki_i   (ki_i),
        .prod_o (prod_q)
    );

    pwi_wrap_step #(
        .ACC_W  (ACC_W),
        .PROD_W (PROD_W),
        .OUT_W  (OUT_W),
        .FRAC_W (FRAC_W)
    ) u_step (
        .acc_i  (acc_q),
        .prod_i (prod_q),
        .hi_i   (lim_hi_i),
        .lo_i   (lim_lo_i),
        .wrap_i (wrap_amt_i),
        .nxt_o  (acc_nxt),
        .kind_o (kind)
    );

    assign pre_ext = {{HEAD_W{pre_val_i[OUT_W-1]}}, pre_val_i, {FRAC_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            wrap_up_o  <= 1'b0;
            wrap_dn_o  <= 1'b0;
            wrap_err_o <= 1'b0;
        end else if (pre_we_i) begin
            acc_q     <= pre_ext;
            wrap_up_o <= 1'b0;
            wrap_dn_o <= 1'b0;
        end else begin
            acc_q     <= acc_nxt;
            wrap_up_o <= (kind == STEP_UP);
            wrap_dn_o <= (kind == STEP_DN);
            if (is_clamp(kind)) begin
                wrap_err_o <= 1'b1;
            end
        end
    end

    pwi_out_round #(
        .ACC_W  (ACC_W),
        .OUT_W  (OUT_W),
        .FRAC_W (FRAC_W)
    ) u_round (
        .acc_i (acc_q),
        .out_o (int_o)
    );

endmodule

// File: rtl/pwi_integrator_chk.sv
module pwi_integrator_chk #(
    parameter int OUT_W = 16
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pre_we_i,
    input logic signed [OUT_W-1:0] pre_val_i,
    input logic signed [OUT_W-1:0] lim_hi_i,
    input logic signed [OUT_W-1:0] lim_lo_i,
    input logic signed [OUT_W-1:0] int_o,
    input logic                    wrap_up_o,
    input logic                    wrap_dn_o,
    input logic                    wrap_err_o
);

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(wrap_up_o && wrap_dn_o)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        wrap_err_o |=> wrap_err_o); // R4

    AST_PRELOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pre_we_i)) |-> (int_o == $past(pre_val_i))); // R5

    AST_PRELOAD_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(pre_we_i)) |-> (!wrap_up_o && !wrap_dn_o)); // R6

    AST_OUT_IN_LIMITS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(pre_we_i) && ($past(lim_lo_i) <= $past(lim_hi_i)))
        |-> ((int_o <= $past(lim_hi_i)) && (int_o >= $past(lim_lo_i)))); // R8

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (int_o == '0 && !wrap_up_o && !wrap_dn_o && !wrap_err_o)); // R10

endmodule

bind pwi_phase_integrator pwi_integrator_chk #(
    .OUT_W (OUT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pre_we_i   (pre_we_i),
    .pre_val_i  (pre_val_i),
    .lim_hi_i   (lim_hi_i),
    .lim_lo_i   (lim_lo_i),
    .int_o      (int_o),
    .wrap_up_o  (wrap_up_o),
    .wrap_dn_o  (wrap_dn_o),
    .wrap_err_o (wrap_err_o)
);

// File: tb/tb_pwi_phase_integrator.sv
`timescale 1ns/1ps
module tb_pwi_phase_integrator;

    localparam int ERR_W  = 14;
    localparam int KI_W   = 13;
    localparam int OUT_W  = 16;
    localparam int FRAC_W = 8;
    localparam longint SCALE = longint'(1) << FRAC_W;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic signed [ERR_W-1:0] err_i = '0;
    logic signed [KI_W-1:0]  ki_i = '0;
    logic signed [OUT_W-1:0] lim_hi_i = 16'sd30000;
    logic signed [OUT_W-1:0] lim_lo_i = -16'sd30000;
    logic        [OUT_W-1:0] wrap_amt_i = 16'd20000;
    logic                    pre_we_i = 1'b0;
    logic signed [OUT_W-1:0] pre_val_i = '0;
    logic signed [OUT_W-1:0] int_o;
    logic                    wrap_up_o, wrap_dn_o, wrap_err_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;
    string phase = "R10";

    // Behavioural reference state
    longint m_acc = 0, m_prod = 0;
    bit     m_up = 0, m_dn = 0, m_err = 0;

    always #2 clk = ~clk;

    pwi_phase_integrator #(
        .ERR_W (ERR_W), .KI_W (KI_W), .OUT_W (OUT_W), .FRAC_W (FRAC_W)
    ) dut (
        .clk (clk), .rst (rst), .err_i (err_i), .ki_i (ki_i),
        .lim_hi_i (lim_hi_i), .lim_lo_i (lim_lo_i), .wrap_amt_i (wrap_amt_i),
        .pre_we_i (pre_we_i), .pre_val_i (pre_val_i), .int_o (int_o),
        .wrap_up_o (wrap_up_o), .wrap_dn_o (wrap_dn_o), .wrap_err_o (wrap_err_o)
    );

    always @(posedge clk) begin
        longint sum, hi, lo, w, nxt;
        if (rst) begin
            m_acc = 0; m_prod = 0; m_up = 0; m_dn = 0; m_err = 0;
        end else begin
            m_up = 0; m_dn = 0;
            hi = longint'(lim_hi_i) * SCALE;
            lo = longint'(lim_lo_i) * SCALE;
            if (pre_we_i) begin
                nxt = longint'(pre_val_i) * SCALE;
            end else begin
                sum = m_acc + m_prod;
                nxt = sum;
                if (sum > hi) begin
                    w = sum - longint'(wrap_amt_i) * SCALE;
                    if (w <= hi && w >= lo) begin nxt = w; m_up = 1; end
                    else begin nxt = hi; m_err = 1; end
                end else if (sum < lo) begin
                    w = sum + longint'(wrap_amt_i) * SCALE;
                    if (w <= hi && w >= lo) begin nxt = w; m_dn = 1; end
                    else begin nxt = lo; m_err = 1; end
                end
            end
            m_acc  = nxt;
            m_prod = longint'(err_i) * longint'(ki_i);
        end
    end

    always @(negedge clk) begin
        longint exp_out;
        if (!finished) begin
            exp_out = m_acc / SCALE;
            n_cmp++;
            if (longint'(int_o) != exp_out || wrap_up_o != m_up ||
                wrap_dn_o != m_dn || wrap_err_o != m_err) begin
                n_bad++;
                $display("FAIL %s: int_o=%0d exp=%0d up=%0b exp=%0b dn=%0b exp=%0b err=%0b exp=%0b",
                         phase, int_o, exp_out, wrap_up_o, m_up, wrap_dn_o, m_dn,
                         wrap_err_o, m_err);
            end
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic preload(input int v);
        @(negedge clk);
        pre_we_i  = 1'b1;
        pre_val_i = OUT_W'(v);
        @(negedge clk);
        pre_we_i  = 1'b0;
    endtask

    task automatic do_reset();
        phase = "R10";
        @(negedge clk);
        rst = 1'b1; err_i = '0; ki_i = '0;
        cycles(3);
        rst = 1'b0;
        cycles(2);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, exp=done");
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        cycles(4);
        rst = 1'b0;
        cycles(2);

        // R1: steady accumulation, two-edge latency from error to output
        phase = "R1";
        err_i = 14'sd100; ki_i = 13'sd3;
        cycles(20);
        err_i = -14'sd250; ki_i = 13'sd7;
        cycles(20);
        err_i = '0;
        cycles(3);

        // R5: preload positive and negative values
        phase = "R5";
        preload(1234);
        cycles(2);
        preload(-1234);
        cycles(2);

        // R9: small negative sums round toward zero
        phase = "R9";
        preload(0);
        err_i = -14'sd1; ki_i = 13'sd1;
        cycles(300);
        err_i = 14'sd3;
        cycles(300);
        err_i = '0;
        cycles(3);

        // R6: preload while a large product is being accumulated
        phase = "R6";
        err_i = 14'sd4000; ki_i = 13'sd2000;
        cycles(3);
        preload(-500);
        preload(777);
        err_i = '0;
        cycles(3);

        // R2: upper crossings wrap down by one period
        phase = "R2";
        lim_hi_i = 16'sd1000; lim_lo_i = -16'sd1000; wrap_amt_i = 16'd1500;
        preload(900);
        err_i = 14'sd100; ki_i = 13'sd100;
        cycles(120);
        err_i = '0;
        cycles(3);

        // R3: lower crossings wrap up by one period
        phase = "R3";
        err_i = -14'sd90; ki_i = 13'sd120;
        cycles(120);
        err_i = '0;
        cycles(3);

        // R8 and R11: mixed random errors inside a narrow window
        phase = "R8";
        lim_hi_i = 16'sd2000; lim_lo_i = -16'sd500; wrap_amt_i = 16'd1800;
        ki_i = 13'sd900;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            err_i = ERR_W'($signed($urandom_range(0, 1200)) - 600);
            if (i % 97 == 50) phase = "R11";
        end
        err_i = '0;
        cycles(3);

        // R4: wrap larger than the limit span forces a clamp and sticky flag
        phase = "R4";
        lim_hi_i = 16'sd1000; lim_lo_i = -16'sd1000; wrap_amt_i = 16'd3000;
        preload(990);
        err_i = 14'sd200; ki_i = 13'sd200;
        cycles(10);
        err_i = -14'sd200;
        cycles(30);
        err_i = '0;
        cycles(3);

        // R10: reset clears the sticky flag, pulses and the integral
        do_reset();

        // R7: guard-bit overflow in both directions
        phase = "R7";
        lim_hi_i = 16'sd1000; lim_lo_i = -16'sd1000; wrap_amt_i = 16'd60000;
        preload(1000);
        err_i = -14'sd8192; ki_i = -13'sd4096;
        cycles(4);
        err_i = '0;
        cycles(2);
        do_reset();
        phase = "R7";
        preload(-1000);
        err_i = -14'sd8192; ki_i = 13'sd4095;
        cycles(4);
        err_i = '0;
        cycles(3);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule